// File: doc/BRIEF.md
# SD Card Bit-Level Serial Engine

This block moves single bits or whole bytes between a host register interface and an SD card, over either the command line or one data line. The host first writes a small configuration word. That word selects the step size, the line, the direction, the card-select level and the card clock rate. The host then writes the data register. Each data write sends a short burst of card clocks, one per bit. A read uses the same dummy write, and the value written is then thrown away. During the burst the engine drives the chosen line, or samples it, and the data register collects what was sampled.

The engine is a three-state machine. `ST_IDLE` holds the card clock low. `ST_CLK_LO` is the low half of a bit period; the output bit is already set up while it lasts. `ST_CLK_HI` is the high half of the bit period. The transitions are:
- start: `ST_IDLE` to `ST_CLK_LO`, on a data write.
- rise: `ST_CLK_LO` to `ST_CLK_HI`, when the half-period tick fires; in read mode the selected line is sampled at this point.
- next bit: `ST_CLK_HI` to `ST_CLK_LO`, on the tick, when more bits remain.
- finish: `ST_CLK_HI` to `ST_IDLE`, on the tick after the last bit.

A rate divider sets the half-period for each rate choice. The slowest choice keeps the card clock at or below 400 kHz.

Top module: `sd_bitbang_engine`

## Requirements
- R1: After reset, the engine is idle with these values: `busy`=0, `sd_clk`=0, `sd_cs`=0, data register 0x00, and neither line driven (both enables 0, both outputs 1).
- R2: A data write while idle makes `busy` high from the next cycle. `busy` stays high until the last card clock has fallen. The burst has 8 rising edges when config bit 5 is 0, and 1 rising edge when config bit 5 is 1.
- R3: In 8-bit write mode, the written byte goes out most significant bit first, one bit per card clock. The line changes only while the card clock is low, so each bit is steady at the rising edge.
- R4: In 1-bit write mode, the single clocked bit is bit 0 of the written value.
- R5: Config bit 4 picks the line: 0 is the command line, 1 is the data line. The line not picked is never driven (enable 0, output 1).
- R6: In read mode (config bit 3 = 1), neither line is driven and the value of the dummy write is ignored. An 8-bit read leaves the sampled bits in register bits 7:0, the first sampled bit in bit 7.
- R7: A 1-bit read shifts the register left by one and places the sampled bit in bit 0, so the old bits 6:0 move up to bits 7:1.
- R8: Config bits 1:0 set the card clock period in system clocks (default parameters, 200 MHz system clock): 00 gives 4, 01 gives 8, 10 and 11 give 500 (400 kHz). A burst keeps `busy` high for the bit count times this period.
- R9: `sd_cs` takes config bit 2 in the cycle after an idle config write.
- R10: Data writes and config writes that arrive while `busy` is high are ignored.
- R11: `sd_clk` is low whenever the engine is idle.
- R12: After a write-mode burst, the data register reads back the value that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_wdata | input | 6 | Config word: [5] one-bit step, [4] data line, [3] read, [2] card select, [1:0] rate |
| dat_we | input | 1 | Data write strobe; starts a burst |
| dat_wdata | input | 8 | Value to send (ignored in read mode) |
| dat_rdata | output | 8 | Data register |
| busy | output | 1 | Burst in progress |
| sd_clk | output | 1 | Card clock |
| sd_cs | output | 1 | Card select level |
| sd_cmd_out | output | 1 | Command line output value |
| sd_cmd_oe | output | 1 | Command line output enable |
| sd_cmd_in | input | 1 | Command line input |
| sd_dat_out | output | 1 | Data line output value |
| sd_dat_oe | output | 1 | Data line output enable |
| sd_dat_in | input | 1 | Data line input |

## Verification
The hardest case to reach from the ports is a 1-bit read. It has to keep bits that an earlier access left in the register. The bench first runs a full 8-bit read from a modelled card to put a known byte in the register. It then runs two 1-bit reads and checks that the earlier bits move up. Strobes that arrive while busy are hard to reach as well. For these, the bench task starts a burst, then writes new data and a new config mid-burst. It then checks that the captured line pattern, the edge count and the card select level are unchanged.

// File: rtl/sdse_pkg.sv
package sdse_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLK_LO = 2'd1,
        ST_CLK_HI = 2'd2
    } sdse_state_e;

    typedef struct packed {
        logic       one_bit;
        logic       use_dat;
        logic       rd;
        logic       cs;
        logic [1:0] rate;
    } sdse_cfg_t;

    localparam int CFG_W = 6;
endpackage

// File: rtl/sdse_rate_div.sv
module sdse_rate_div #(
    parameter int SYS_CLK_HZ  = 200_000_000,
    parameter int FAST_HZ     = 50_000_000,
    parameter int MID_HZ      = 25_000_000,
    parameter int INIT_MAX_HZ = 400_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int HALF_FAST_RAW = SYS_CLK_HZ / (2 * FAST_HZ);
    localparam int HALF_MID_RAW  = SYS_CLK_HZ / (2 * MID_HZ);
    localparam int HALF_INIT_RAW = (SYS_CLK_HZ + 2 * INIT_MAX_HZ - 1) / (2 * INIT_MAX_HZ);
    localparam int HALF_FAST = (HALF_FAST_RAW < 1) ? 1 : HALF_FAST_RAW;
    localparam int HALF_MID  = (HALF_MID_RAW  < 1) ? 1 : HALF_MID_RAW;
    localparam int HALF_INIT = (HALF_INIT_RAW < 1) ? 1 : HALF_INIT_RAW;
    localparam int CNT_W     = $clog2(HALF_INIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        unique case (rate)
            2'b00:   limit = CNT_W'(HALF_FAST - 1);
            2'b01:   limit = CNT_W'(HALF_MID - 1);
            default: limit = CNT_W'(HALF_INIT - 1);
        endcase
    end

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdse_shift_reg.sv
module sdse_shift_reg #(
    parameter int DATA_W = 8,
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              one_bit,
    output logic [DATA_W-1:0] q,
    output logic              drive_bit
);
    logic [IDX_W-1:0] sel;

    assign sel       = IDX_W'(DATA_W - 1) - bit_idx;
    assign drive_bit = one_bit ? q[0] : q[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift_en) begin
            q <= {q[DATA_W-2:0], shift_bit};
        end
    end
endmodule

// File: rtl/sd_bitbang_engine.sv
module sd_bitbang_engine #(
    parameter int SYS_CLK_HZ  = 200_000_000,
    parameter int FAST_HZ     = 50_000_000,
    parameter int MID_HZ      = 25_000_000,
    parameter int INIT_MAX_HZ = 400_000,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_wdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic [DATA_W-1:0] dat_rdata,
    output logic              busy,
    output logic              sd_clk,
    output logic              sd_cs,
    output logic              sd_cmd_out,
    output logic              sd_cmd_oe,
    input  logic              sd_cmd_in,
    output logic              sd_dat_out,
    output logic              sd_dat_oe,
    input  logic              sd_dat_in
);
    import sdse_pkg::*;

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    sdse_state_e      state_q, state_d;
    sdse_cfg_t        cfg_q;
    logic [IDX_W-1:0] bit_q;
    logic             tick;
    logic             idle;
    logic             start;
    logic             last_bit;
    logic             sample;
    logic             line_in;
    logic             drive_bit;
    logic             driving;

    assign idle     = (state_q == ST_IDLE);
    assign start    = idle && dat_we;
    assign last_bit = cfg_q.one_bit || (bit_q == IDX_W'(DATA_W - 1));
    assign sample   = (state_q == ST_CLK_LO) && tick && cfg_q.rd;
    assign line_in  = cfg_q.use_dat ? sd_dat_in : sd_cmd_in;

    sdse_rate_div #(
        .SYS_CLK_HZ (SYS_CLK_HZ),
        .FAST_HZ    (FAST_HZ),
        .MID_HZ     (MID_HZ),
        .INIT_MAX_HZ(INIT_MAX_HZ)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (!idle),
        .rate (cfg_q.rate),
        .tick (tick)
    );

    sdse_shift_reg #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start && !cfg_q.rd),
        .load_val (dat_wdata),
        .shift_en (sample),
        .shift_bit(line_in),
        .bit_idx  (bit_q),
        .one_bit  (cfg_q.one_bit),
        .q        (dat_rdata),
        .drive_bit(drive_bit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (dat_we) state_d = ST_CLK_LO;
            ST_CLK_LO: if (tick)   state_d = ST_CLK_HI;
            ST_CLK_HI: if (tick)   state_d = last_bit ? ST_IDLE : ST_CLK_LO;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit counter: cleared on start, advanced on each falling card edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (start) begin
            bit_q <= '0;
        end else if ((state_q == ST_CLK_HI) && tick && !last_bit) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    // Configuration accepted only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we && idle) begin
            cfg_q <= sdse_cfg_t'(cfg_wdata);
        end
    end

    // Outputs
    always_comb begin
        busy       = !idle;
        sd_clk     = (state_q == ST_CLK_HI);
        sd_cs      = cfg_q.cs;
        driving    = !idle && !cfg_q.rd;
        sd_cmd_oe  = driving && !cfg_q.use_dat;
        sd_dat_oe  = driving && cfg_q.use_dat;
        sd_cmd_out = sd_cmd_oe ? drive_bit : 1'b1;
        sd_dat_out = sd_dat_oe ? drive_bit : 1'b1;
    end
endmodule

// File: rtl/sdse_checker.sv
module sdse_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [5:0]        cfg_wdata,
    input logic              dat_we,
    input logic [DATA_W-1:0] dat_rdata,
    input logic              busy,
    input logic              sd_clk,
    input logic              sd_cs,
    input logic              sd_cmd_out,
    input logic              sd_cmd_oe,
    input logic              sd_dat_out,
    input logic              sd_dat_oe
);
    a_r11_clk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sd_clk);

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !busy) |=> busy);

    a_r5_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(sd_cmd_oe && sd_dat_oe));

    a_r3_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_clk && $past(sd_clk)) |-> ($stable(sd_cmd_out) && $stable(sd_dat_out)));

    a_r10_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sd_cs));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !dat_we) |=> (!busy && $stable(dat_rdata)));

    a_r9_cs_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !busy) |=> (sd_cs == $past(cfg_wdata[2])));
endmodule

bind sd_bitbang_engine sdse_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .dat_we    (dat_we),
    .dat_rdata (dat_rdata),
    .busy      (busy),
    .sd_clk    (sd_clk),
    .sd_cs     (sd_cs),
    .sd_cmd_out(sd_cmd_out),
    .sd_cmd_oe (sd_cmd_oe),
    .sd_dat_out(sd_dat_out),
    .sd_dat_oe (sd_dat_oe)
);

// File: tb/sd_bitbang_engine_tb.sv
`timescale 1ns/1ps
module sd_bitbang_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       dat_we = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       busy, sd_clk, sd_cs;
    logic       sd_cmd_out, sd_cmd_oe, sd_dat_out, sd_dat_oe;
    logic       sd_cmd_in, sd_dat_in;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // card model and monitors
    logic [7:0] pat_c = '0;
    logic [7:0] pat_d = '0;
    int         card_idx = 0;
    int         cyc = 0;
    int         last_rise = 0;
    int         period = 0;
    int         rise_cnt = 0;
    logic [7:0] cap_c = '0;
    logic [7:0] cap_d = '0;
    bit         cmd_seen = 0;
    bit         dat_seen = 0;

    assign sd_cmd_in = pat_c[3'(7 - card_idx)];
    assign sd_dat_in = pat_d[3'(7 - card_idx)];

    always #2.5 clk = ~clk;

    sd_bitbang_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .busy(busy), .sd_clk(sd_clk), .sd_cs(sd_cs),
        .sd_cmd_out(sd_cmd_out), .sd_cmd_oe(sd_cmd_oe), .sd_cmd_in(sd_cmd_in),
        .sd_dat_out(sd_dat_out), .sd_dat_oe(sd_dat_oe), .sd_dat_in(sd_dat_in)
    );

    always @(posedge clk) cyc++;

    always @(posedge sd_clk) begin
        rise_cnt++;
        period = cyc - last_rise;
        last_rise = cyc;
        if (sd_cmd_oe) cap_c = {cap_c[6:0], sd_cmd_out};
        if (sd_dat_oe) cap_d = {cap_d[6:0], sd_dat_out};
    end

    always @(negedge sd_clk) if (card_idx < 7) card_idx++;

    always @(negedge clk) begin
        if (sd_cmd_oe) cmd_seen = 1;
        if (sd_dat_oe) dat_seen = 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [5:0] v);
        @(negedge clk);
        cfg_wdata = v;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic start_xfer(input logic [7:0] v);
        @(negedge clk);
        rise_cnt = 0; cap_c = '0; cap_d = '0;
        cmd_seen = 0; dat_seen = 0; card_idx = 0;
        dat_wdata = v;
        dat_we = 1'b1;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic finish_xfer(output int n);
        n = 1;
        @(negedge clk);
        while (busy && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 sd_clk", sd_clk, 0);
        check("R1 sd_cs", sd_cs, 0);
        check("R1 rdata", dat_rdata, 0);
        check("R1 oe", {sd_cmd_oe, sd_dat_oe}, 0);
        check("R1 outs", {sd_cmd_out, sd_dat_out}, 2'b11);
    endtask

    task automatic t_cs();
        set_cfg(6'h04);
        check("R9 cs high", sd_cs, 1);
        set_cfg(6'h00);
        check("R9 cs low", sd_cs, 0);
    endtask

    task automatic t_write8_cmd();
        int n;
        set_cfg(6'h00);
        start_xfer(8'hA5);
        check("R2 busy after write", busy, 1);
        finish_xfer(n);
        check("R8 fast cycles", n, 32);
        check("R8 fast period", period, 4);
        check("R2 eight rises", rise_cnt, 8);
        check("R3 msb first cmd", cap_c, 8'hA5);
        check("R5 dat undriven", dat_seen, 0);
        check("R12 readback", dat_rdata, 8'hA5);
        check("R11 clk low idle", sd_clk, 0);
    endtask

    task automatic t_write8_dat();
        int n;
        set_cfg(6'h11);
        start_xfer(8'h3C);
        finish_xfer(n);
        check("R5 dat line data", cap_d, 8'h3C);
        check("R5 cmd undriven", cmd_seen, 0);
        check("R8 mid cycles", n, 64);
        check("R8 mid period", period, 8);
    endtask

    task automatic t_write1();
        int n;
        set_cfg(6'h20);
        start_xfer(8'h01);
        finish_xfer(n);
        check("R2 one rise", rise_cnt, 1);
        check("R4 bit0 one", cap_c[0], 1);
        check("R8 1bit cycles", n, 4);
        start_xfer(8'hFE);
        finish_xfer(n);
        check("R4 bit0 zero", cap_c[0], 0);
    endtask

    task automatic t_read8();
        int n;
        set_cfg(6'h08);
        pat_c = 8'h96;
        pat_d = 8'h00;
        start_xfer(8'h55);
        finish_xfer(n);
        check("R6 read byte", dat_rdata, 8'h96);
        check("R6 no drive", {cmd_seen, dat_seen}, 0);
        check("R6 rises", rise_cnt, 8);
        set_cfg(6'h1A);
        pat_c = 8'hFF;
        pat_d = 8'hC3;
        start_xfer(8'h00);
        finish_xfer(n);
        check("R6 dat line read", dat_rdata, 8'hC3);
        check("R8 init cycles", n, 4000);
        check("R8 init period", period, 500);
    endtask

    task automatic t_read1();
        int n;
        set_cfg(6'h08);
        pat_c = 8'h96;
        start_xfer(8'h00);
        finish_xfer(n);
        set_cfg(6'h28);
        pat_c = 8'h80;
        start_xfer(8'h00);
        finish_xfer(n);
        check("R7 shift in one", dat_rdata, 8'h2D);
        pat_c = 8'h00;
        start_xfer(8'hFF);
        finish_xfer(n);
        check("R7 shift in zero", dat_rdata, 8'h5A);
        check("R7 one rise", rise_cnt, 1);
    endtask

    task automatic t_rate3();
        int n;
        set_cfg(6'h23);
        start_xfer(8'h01);
        finish_xfer(n);
        check("R8 rate 11 cycles", n, 500);
    endtask

    task automatic t_busy_ignore();
        int n;
        set_cfg(6'h04);
        start_xfer(8'hA5);
        dat_wdata = 8'h00;
        dat_we = 1'b1;
        @(negedge clk);
        dat_we = 1'b0;
        cfg_wdata = 6'h31;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        n = 2;
        finish_xfer(n);
        check("R10 pattern kept", cap_c, 8'hA5);
        check("R10 rises kept", rise_cnt, 8);
        check("R10 cs kept", sd_cs, 1);
        check("R10 data kept", dat_rdata, 8'hA5);
        @(negedge clk);
        check("R10 still idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cs();
        t_write8_cmd();
        t_write8_dat();
        t_write1();
        t_read8();
        t_read1();
        t_rate3();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule